// File: doc/BRIEF.md
# Flat-Panel Pixel Lane Serializer

This block turns a stream of parallel pixels into the serial lanes of a low-voltage differential flat-panel link. It runs entirely on the fast bit clock, which is seven times the pixel rate. An internal slot counter divides that clock into pixel periods of seven bit slots. Once per period the block captures red, green and blue (8 bits each) together with horizontal sync, vertical sync and data enable. It arranges the captured bits into one 7-bit word per lane. Over the next seven bit-clock cycles it shifts those words out, one slot per cycle. The full words are also presented in parallel, so an external serializer can be used in place of the bit-serial outputs. A forwarded clock lane pattern is generated alongside the data.

A static two-bit select chooses how colour bits are placed into slots. One layout is 18-bit and uses three lanes. The other two are 24-bit layouts on four lanes, and they differ in which colour bits travel on the fourth lane. A mirror input reverses the slot order on every data lane. Both selects, and all pixel inputs, are sampled only when a pixel is captured. The upstream source watches the capture strobe and holds its pixel steady across the cycle in which that strobe is high.

Top module: `lvds_lane_ser`

## Requirements
- R1: Each pixel period is 7 bit-clock cycles, with slots 0 to 6 in that order. `laneWord` bit 7L+s holds the bit that lane L sends in slot s, and `laneSer[L]` equals that bit while the period is in slot s. `pixTake` is high exactly during slot 6. The inputs present in that cycle are captured at its closing edge and are transmitted from the following slot 0.
- R2: `clkLaneSer` is 1 in slots 0, 1, 5 and 6 and is 0 in slots 2, 3 and 4.
- R3: With `mapSel` = 00 or 11 (18-bit layout), each colour is reduced to its upper six bits c[7:2]. Lane 0 sends g2, r7, r6, r5, r4, r3, r2 in slots 0 to 6. Lane 1 sends b3, b2, g7, g6, g5, g4, g3. Lane 2 sends the three control bits (see R6) and then b7, b6, b5, b4. Lane 3 is all 0. Colour bits 1 and 0 have no effect.
- R4: With `mapSel` = 01 (24-bit layout A), lanes 0 to 2 are as in R3. Lane 3 sends 0, b1, b0, g1, g0, r1, r0 in slots 0 to 6.
- R5: With `mapSel` = 10 (24-bit layout B), lanes 0 to 2 use the low six bits c[5:0] in the same positions. Lane 0 sends g0, r5..r0. Lane 1 sends b1, b0, g5..g1. Lane 2 sends the control bits and then b5..b2. Lane 3 sends 0, b7, b6, g7, g6, r7, r6.
- R6: In lane 2, slot 0 carries data enable, slot 1 carries vertical sync and slot 2 carries horizontal sync. Slot 0 of lane 3 is always 0.
- R7: With `mirror` = 1, every data lane sends its word reversed: slot s carries the bit that slot 6-s would carry with `mirror` = 0.
- R8: Changes on the pixel inputs, `mapSel` or `mirror` outside the capture cycle do not alter the word being sent. `laneWord` changes only at the edge that ends slot 6.
- R9: While `rstN` is low and for the first 7 cycles after its release, `laneWord` and `laneSer` are 0. The slot counter begins at slot 0 when reset is released, so the first capture falls on the 7th cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, seven times the pixel rate |
| rstN | input | 1 | Asynchronous active-low reset |
| red | input | 8 | Red component |
| green | input | 8 | Green component |
| blue | input | 8 | Blue component |
| hsync | input | 1 | Horizontal sync |
| vsync | input | 1 | Vertical sync |
| de | input | 1 | Data enable |
| mapSel | input | 2 | Slot layout: 00/11 18-bit, 01 24-bit A, 10 24-bit B |
| mirror | input | 1 | Reverse slot order on all data lanes |
| pixTake | output | 1 | High in the cycle whose closing edge captures the inputs |
| laneSer | output | 4 | Serial data lanes, one bit per slot |
| clkLaneSer | output | 1 | Forwarded clock lane pattern |
| laneWord | output | 28 | Per-lane 7-bit words; bit 7L+s is slot s of lane L |

## Verification
The checker keeps its own slot count from reset and checks four things on every cycle. It confirms the slot in which the capture strobe fires and the clock-lane pattern for each slot. It confirms that each serial bit agrees with the matching bit of the parallel word. It also confirms that the words never move except at a period boundary. In addition it checks that lane 3 is silent after an 18-bit capture and that the always-zero control slot stays zero under either slot order. The actual colour-to-slot layouts, the mirror reversal, the unused low colour bits and the reset behaviour can only be shown by the bench. The bench compares every slot against an independent model of the three layouts, under both directed and random pixels. After each capture it also scrambles the inputs in mid-period.

// File: rtl/lvds_ser_pkg.sv
package lvds_ser_pkg;

  localparam int SLOTS_DEF   = 7;
  localparam int LANES_DEF   = 4;
  localparam int COLOR_W_DEF = 8;
  localparam int SLOT_W      = $clog2(SLOTS_DEF);

  typedef enum logic [1:0] {
    MAP_18    = 2'b00,
    MAP_24A   = 2'b01,
    MAP_24B   = 2'b10,
    MAP_18ALT = 2'b11
  } mapSel_e;

  typedef struct packed {
    logic [COLOR_W_DEF-1:0] red;
    logic [COLOR_W_DEF-1:0] green;
    logic [COLOR_W_DEF-1:0] blue;
    logic                   hsync;
    logic                   vsync;
    logic                   de;
  } pixel_t;

  // Strobes from the slot control to the lane datapath
  typedef struct packed {
    logic              take;
    logic [SLOT_W-1:0] slot;
  } slotCtl_t;

endpackage

// File: rtl/lvds_slot_ctrl.sv
module lvds_slot_ctrl
  import lvds_ser_pkg::*;
#(
  parameter int SLOTS = SLOTS_DEF
) (
  input  logic     clk,
  input  logic     rstN,
  output slotCtl_t ctl
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  logic [SLOT_W-1:0] slotQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotQ <= '0;
    end else if (slotQ == LAST_SLOT) begin
      slotQ <= '0;
    end else begin
      slotQ <= slotQ + 1'b1;
    end
  end

  always_comb begin
    ctl.take = (slotQ == LAST_SLOT);
    ctl.slot = slotQ;
  end

endmodule

// File: rtl/lvds_lane_mapper.sv
module lvds_lane_mapper
  import lvds_ser_pkg::*;
#(
  parameter int LANES = LANES_DEF,
  parameter int SLOTS = SLOTS_DEF
) (
  input  pixel_t                   pix,
  input  logic [1:0]               mapSel,
  output logic [LANES*SLOTS-1:0]   rawWords
);

  localparam int HI_W = 6;
  localparam int EX_W = COLOR_W_DEF - HI_W;

  mapSel_e mode;
  logic    useLowSix;
  logic    lane3On;
  logic [HI_W-1:0] hiR, hiG, hiB;
  logic [EX_W-1:0] exR, exG, exB;

  always_comb begin
    mode      = mapSel_e'(mapSel);
    useLowSix = (mode == MAP_24B);
    lane3On   = (mode == MAP_24A) || (mode == MAP_24B);

    // Six-bit operands for lanes 0..2
    hiR = useLowSix ? pix.red[HI_W-1:0]   : pix.red[COLOR_W_DEF-1:EX_W];
    hiG = useLowSix ? pix.green[HI_W-1:0] : pix.green[COLOR_W_DEF-1:EX_W];
    hiB = useLowSix ? pix.blue[HI_W-1:0]  : pix.blue[COLOR_W_DEF-1:EX_W];

    // Remaining two bits of each colour for lane 3
    exR = useLowSix ? pix.red[COLOR_W_DEF-1:HI_W]   : pix.red[EX_W-1:0];
    exG = useLowSix ? pix.green[COLOR_W_DEF-1:HI_W] : pix.green[EX_W-1:0];
    exB = useLowSix ? pix.blue[COLOR_W_DEF-1:HI_W]  : pix.blue[EX_W-1:0];

    rawWords = '0;
    // Bit s of each lane word is slot s
    rawWords[0*SLOTS +: SLOTS] = {hiR[0], hiR[1], hiR[2], hiR[3], hiR[4], hiR[5], hiG[0]};
    rawWords[1*SLOTS +: SLOTS] = {hiG[1], hiG[2], hiG[3], hiG[4], hiG[5], hiB[0], hiB[1]};
    rawWords[2*SLOTS +: SLOTS] = {hiB[2], hiB[3], hiB[4], hiB[5], pix.hsync, pix.vsync, pix.de};
    rawWords[3*SLOTS +: SLOTS] = lane3On ?
      {exR[0], exR[1], exG[0], exG[1], exB[0], exB[1], 1'b0} : '0;
  end

endmodule

// File: rtl/lvds_lane_path.sv
module lvds_lane_path
  import lvds_ser_pkg::*;
#(
  parameter int LANES = LANES_DEF,
  parameter int SLOTS = SLOTS_DEF
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  pixel_t                 pix,
  input  logic [1:0]             mapSel,
  input  logic                   mirror,
  input  slotCtl_t               ctl,
  output logic [LANES-1:0]       laneSer,
  output logic                   clkLaneSer,
  output logic [LANES*SLOTS-1:0] laneWord
);

  localparam int WORD_W    = LANES * SLOTS;
  localparam int CLK_HEAD  = 2;
  localparam int CLK_TAIL  = 2;
  localparam logic [SLOT_W-1:0] HEAD_END   = SLOT_W'(CLK_HEAD);
  localparam logic [SLOT_W-1:0] TAIL_START = SLOT_W'(SLOTS - CLK_TAIL);

  logic [WORD_W-1:0] rawWords;
  logic [WORD_W-1:0] orderedWords;
  logic [WORD_W-1:0] wordQ;

  lvds_lane_mapper #(
    .LANES (LANES),
    .SLOTS (SLOTS)
  ) mapper_i (
    .pix      (pix),
    .mapSel   (mapSel),
    .rawWords (rawWords)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SLOTS-1:0] laneQ;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      assign orderedWords[l*SLOTS + s] =
        mirror ? rawWords[l*SLOTS + (SLOTS-1-s)] : rawWords[l*SLOTS + s];
    end

    assign laneQ      = wordQ[l*SLOTS +: SLOTS];
    assign laneSer[l] = laneQ[ctl.slot];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordQ <= '0;
    end else if (ctl.take) begin
      wordQ <= orderedWords;
    end
  end

  assign clkLaneSer = (ctl.slot < HEAD_END) || (ctl.slot >= TAIL_START);
  assign laneWord   = wordQ;

endmodule

// File: rtl/lvds_lane_ser.sv
module lvds_lane_ser
  import lvds_ser_pkg::*;
#(
  parameter int LANES   = LANES_DEF,
  parameter int SLOTS   = SLOTS_DEF,
  parameter int COLOR_W = COLOR_W_DEF
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [COLOR_W-1:0]     red,
  input  logic [COLOR_W-1:0]     green,
  input  logic [COLOR_W-1:0]     blue,
  input  logic                   hsync,
  input  logic                   vsync,
  input  logic                   de,
  input  logic [1:0]             mapSel,
  input  logic                   mirror,
  output logic                   pixTake,
  output logic [LANES-1:0]       laneSer,
  output logic                   clkLaneSer,
  output logic [LANES*SLOTS-1:0] laneWord
);

  pixel_t   pix;
  slotCtl_t ctl;

  assign pix.red   = red;
  assign pix.green = green;
  assign pix.blue  = blue;
  assign pix.hsync = hsync;
  assign pix.vsync = vsync;
  assign pix.de    = de;

  lvds_slot_ctrl #(
    .SLOTS (SLOTS)
  ) ctrl_i (
    .clk  (clk),
    .rstN (rstN),
    .ctl  (ctl)
  );

  lvds_lane_path #(
    .LANES (LANES),
    .SLOTS (SLOTS)
  ) path_i (
    .clk        (clk),
    .rstN       (rstN),
    .pix        (pix),
    .mapSel     (mapSel),
    .mirror     (mirror),
    .ctl        (ctl),
    .laneSer    (laneSer),
    .clkLaneSer (clkLaneSer),
    .laneWord   (laneWord)
  );

  assign pixTake = ctl.take;

endmodule

// File: rtl/lvds_lane_ser_chk.sv
module lvds_lane_ser_chk #(
  parameter int LANES = 4,
  parameter int SLOTS = 7
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [1:0]             mapSel,
  input logic                   mirror,
  input logic                   pixTake,
  input logic [LANES-1:0]       laneSer,
  input logic                   clkLaneSer,
  input logic [LANES*SLOTS-1:0] laneWord
);

  localparam int CW = $clog2(SLOTS);
  localparam logic [CW-1:0] LAST = CW'(SLOTS - 1);
  localparam int TOP_LANE = LANES - 1;

  logic [CW-1:0] chkSlot;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               chkSlot <= '0;
    else if (chkSlot == LAST) chkSlot <= '0;
    else                     chkSlot <= chkSlot + 1'b1;
  end

  p_take_slot_r1: assert property (@(posedge clk) disable iff (!rstN)
    pixTake == (chkSlot == LAST));

  for (genvar l = 0; l < LANES; l++) begin : g_ser
    logic [SLOTS-1:0] laneBits;
    assign laneBits = laneWord[l*SLOTS +: SLOTS];
    p_ser_word_r1: assert property (@(posedge clk) disable iff (!rstN)
      laneSer[l] == laneBits[chkSlot]);
  end

  p_clk_lane_r2: assert property (@(posedge clk) disable iff (!rstN)
    clkLaneSer == ((chkSlot <= CW'(1)) || (chkSlot >= CW'(SLOTS - 2))));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !pixTake |=> $stable(laneWord));

  p_lane3_off_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pixTake && (mapSel == 2'b00 || mapSel == 2'b11)) |=>
      laneWord[TOP_LANE*SLOTS +: SLOTS] == '0);

  p_ctl3_plain_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pixTake && !mirror) |=> laneWord[TOP_LANE*SLOTS] == 1'b0);

  p_ctl3_mirror_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pixTake && mirror) |=> laneWord[TOP_LANE*SLOTS + SLOTS - 1] == 1'b0);

endmodule

bind lvds_lane_ser lvds_lane_ser_chk #(
  .LANES (LANES),
  .SLOTS (SLOTS)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .mapSel     (mapSel),
  .mirror     (mirror),
  .pixTake    (pixTake),
  .laneSer    (laneSer),
  .clkLaneSer (clkLaneSer),
  .laneWord   (laneWord)
);

// File: tb/lvds_lane_ser_tb_top.sv
module lvds_lane_ser_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  red, green, blue;
  logic        hsync, vsync, de;
  logic [1:0]  mapSel;
  logic        mirror;
  logic        pixTake;
  logic [3:0]  laneSer;
  logic        clkLaneSer;
  logic [27:0] laneWord;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  lvds_lane_ser dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .red        (red),
    .green      (green),
    .blue       (blue),
    .hsync      (hsync),
    .vsync      (vsync),
    .de         (de),
    .mapSel     (mapSel),
    .mirror     (mirror),
    .pixTake    (pixTake),
    .laneSer    (laneSer),
    .clkLaneSer (clkLaneSer),
    .laneWord   (laneWord)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Independent model: slot s of one lane, per the requirement text
  function automatic logic [6:0] expWord(input int lane, input logic [7:0] r,
      input logic [7:0] g, input logic [7:0] b, input logic hs, input logic vs,
      input logic den, input logic [1:0] ms, input logic mir);
    logic [6:0] w;
    logic [6:0] m;
    int off;
    int xo;
    bit narrow;
    narrow = (ms == 2'b00) || (ms == 2'b11);
    off    = (ms == 2'b10) ? 0 : 2;
    xo     = (ms == 2'b10) ? 6 : 0;
    for (int s = 0; s < 7; s++) begin
      case (lane)
        0: w[s] = (s == 0) ? g[off] : r[6 + off - s];
        1: w[s] = (s < 2) ? b[off + 1 - s] : g[7 + off - s];
        2: begin
          if (s == 0)      w[s] = den;
          else if (s == 1) w[s] = vs;
          else if (s == 2) w[s] = hs;
          else             w[s] = b[8 + off - s];
        end
        default: begin
          if (narrow || s == 0) w[s] = 1'b0;
          else begin
            case (s)
              1: w[s] = b[xo + 1];
              2: w[s] = b[xo];
              3: w[s] = g[xo + 1];
              4: w[s] = g[xo];
              5: w[s] = r[xo + 1];
              default: w[s] = r[xo];
            endcase
          end
        end
      endcase
    end
    for (int s = 0; s < 7; s++) m[s] = mir ? w[6 - s] : w[s];
    return m;
  endfunction

  function automatic logic expClk(input int s);
    return (s == 0 || s == 1 || s == 5 || s == 6);
  endfunction

  task automatic setPix(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b,
                        input logic hs, input logic vs, input logic den,
                        input logic [1:0] ms, input logic mir);
    red = r; green = g; blue = b; hsync = hs; vsync = vs; de = den;
    mapSel = ms; mirror = mir;
  endtask

  task automatic scramble();
    red = 8'($urandom); green = 8'($urandom); blue = 8'($urandom);
    hsync = 1'($urandom); vsync = 1'($urandom); de = 1'($urandom);
    mapSel = 2'($urandom); mirror = 1'($urandom);
  endtask

  // Called at a negedge in slot 6 with the pixel already driven.
  // Ends at the negedge of the next slot 6.
  task automatic runPeriod(input string tag, output logic [27:0] seen);
    logic [6:0]  ew [4];
    logic [27:0] expAll;
    logic [3:0]  expSer;
    for (int l = 0; l < 4; l++)
      ew[l] = expWord(l, red, green, blue, hsync, vsync, de, mapSel, mirror);
    expAll = {ew[3], ew[2], ew[1], ew[0]};
    seen = '0;
    for (int s = 0; s < 7; s++) begin
      @(negedge clk);
      if (s == 0) seen = laneWord;
      for (int l = 0; l < 4; l++) expSer[l] = ew[l][s];
      chk((s < 3) ? tag : "R8", $sformatf("laneWord slot%0d", s), 32'(laneWord), 32'(expAll));
      chk("R1", $sformatf("laneSer slot%0d", s), 32'(laneSer), 32'(expSer));
      chk("R2", $sformatf("clkLaneSer slot%0d", s), 32'(clkLaneSer), 32'(expClk(s)));
      chk("R1", $sformatf("pixTake slot%0d", s), 32'(pixTake), 32'(s == 6));
      if (s == 2) scramble();
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    logic [27:0] wA;
    logic [27:0] wB;
    string tag;
    void'($urandom(32'h1A2B3C4D));
    rstN = 1'b0;
    setPix(8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1, 2'b01, 1'b0);
    repeat (3) @(negedge clk);
    chk("R9", "laneWord in reset", 32'(laneWord), 32'h0);
    chk("R9", "laneSer in reset", 32'(laneSer), 32'h0);
    chk("R9", "pixTake in reset", 32'(pixTake), 32'h0);
    rstN = 1'b1;
    #1;
    chk("R2", "clkLaneSer slot0 after reset", 32'(clkLaneSer), 32'h1);
    for (int k = 1; k < 7; k++) begin
      @(negedge clk);
      chk("R9", $sformatf("laneWord zero cycle %0d", k), 32'(laneWord), 32'h0);
      chk("R9", $sformatf("laneSer zero cycle %0d", k), 32'(laneSer), 32'h0);
      chk("R9", $sformatf("pixTake cycle %0d", k), 32'(pixTake), 32'(k == 6));
      chk("R2", $sformatf("clkLaneSer cycle %0d", k), 32'(clkLaneSer), 32'(expClk(k)));
    end

    // Directed: all ones in the 18-bit layout, lane 3 stays silent
    setPix(8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1, 2'b00, 1'b0);
    runPeriod("R3", wA);
    // Control slots alone
    setPix(8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 2'b01, 1'b0);
    runPeriod("R6", wA);
    setPix(8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 2'b10, 1'b0);
    runPeriod("R6", wA);
    // Low colour bits ignored in 18-bit layout
    setPix(8'hA4, 8'h58, 8'hC8, 1'b0, 1'b1, 1'b1, 2'b00, 1'b0);
    runPeriod("R3", wA);
    setPix(8'hA7, 8'h5B, 8'hCB, 1'b0, 1'b1, 1'b1, 2'b00, 1'b0);
    runPeriod("R3", wB);
    chk("R3", "low colour bits changed word", 32'(wB), 32'(wA));
    // Select 11 behaves as 18-bit
    setPix(8'hA7, 8'h5B, 8'hCB, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0);
    runPeriod("R3", wB);
    chk("R3", "select 11 differs from 00", 32'(wB), 32'(wA));
    // Single bits on lane 3 in both 24-bit layouts
    setPix(8'h01, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 2'b01, 1'b0);
    runPeriod("R4", wA);
    setPix(8'h00, 8'h00, 8'h80, 1'b0, 1'b0, 1'b0, 2'b10, 1'b0);
    runPeriod("R5", wA);
    // Mirror with distinct patterns
    setPix(8'h3C, 8'hC3, 8'h96, 1'b1, 1'b0, 1'b1, 2'b10, 1'b1);
    runPeriod("R7", wA);
    setPix(8'h3C, 8'hC3, 8'h96, 1'b1, 1'b0, 1'b1, 2'b01, 1'b1);
    runPeriod("R7", wA);

    // Random pixels and modes
    for (int n = 0; n < 400; n++) begin
      scramble();
      if (mirror)                 tag = "R7";
      else if (mapSel == 2'b01)   tag = "R4";
      else if (mapSel == 2'b10)   tag = "R5";
      else                        tag = "R3";
      runPeriod(tag, wA);
    end

    finishRun();
  end

endmodule